// File: doc/BRIEF.md
# Data-Side Address Translation Checker

This block judges each data memory request in a single cycle. It takes the request's virtual address, access size, direction and qualifier flags, together with the processor's mode state. It returns a physical address, an uncacheable marker and one fault code. The checks run in a fixed priority order: alignment first, then virtual-address validity, the superpage direct-map window, the TLB lookup, the per-mode permission enables, the fault-on-read/write bits, and last the physical-range check. The TLB is a separate block. This checker presents it with a page number and address-space number and uses the hit, frame number and permission bits that come back in the same cycle.

When a request faults, the block captures the faulting virtual address, a packed status word and a formatted page-table address. Requests that come from a page-table walk, and requests marked as never faulting, leave these registers alone. Six counters sort every request into read or write and into hit, miss or violation.

The response is registered. It appears one clock after the request is presented, and the fault registers and counters change on that same edge.

Top module: `dxl_check`

## Requirements
- R1: When `req_va & ((1 << req_size_log) - 1)` is non-zero, the fault is alignment (code 1) whatever the other inputs are, including the physical flag. The status flag field holds only the write bit (bit 0, set for writes).
- R2: With the physical flag set and the alignment check passed, the physical address equals the virtual address. No TLB result is used.
- R3: A translated request whose virtual-address bits 63:42 are not all equal raises a page fault (code 3). Its flags are bad-VA (bit 2) and violation (bit 1), plus the write bit for writes.
- R4: A translated request with VA[47:41] = 7'h7E maps directly. It is allowed only when `cur_mode` is kernel (0); this ignores the privileged-code override. Otherwise it raises a violation (code 2) with flag bit 1. The physical address is VA[43:0]. If bit 40 is set, bits 43:40 are forced to ones; if not, the address is cut to 40 bits.
- R5: The mode used for the TLB permission checks is `cur_mode` when `pc_priv` is 0. When `pc_priv` is 1 it is kernel, or `alt_mode` if `req_altmode` is set. Modes: 0 kernel, 1 executive, 2 supervisor, 3 user. Enable bit n belongs to mode n.
- R6: A TLB miss gives code 5 when `req_vpte` is set and code 4 otherwise. The flags are miss (bit 5) plus the write bit.
- R7: On a write hit, a clear write enable for the mode gives a page fault with flags write, violation and, when fault-on-write is set, bit 4. If the enable is set but fault-on-write is set, the result is a page fault with flags write and bit 4.
- R8: On a read hit, a clear read enable for the mode gives a violation (code 2) with flags violation and, when fault-on-read is set, bit 3. If the enable is set but fault-on-read is set, the result is a page fault with flag bit 3.
- R9: A hit's physical address is `{lk_ppn, req_va[12:0]}`. A fault-free address with any bit above bit 43 set gives machine check (code 6), and the fault registers do not latch.
- R10: A fault-free address with bit 43 set is marked uncacheable and has bits 42:35 cleared. The exception is when bits 43:32 are all ones (the I/O-register window), which stays unchanged and cacheable.
- R11: On a fault with codes 1 to 5, the block latches three values: the virtual address; the status word {opcode[5:0] at 16:11, Ra[4:0] at 10:6, flags at 5:0}; and `pt_base | (VA[42:13] << 3)`. Nothing is latched when `req_vpte` or `req_nofault` is set.
- R12: Each request adds one to exactly one counter, chosen by direction. Codes 0 and 6 count as hit, codes 4 and 5 as miss, and codes 2 and 3 as violation. Alignment faults are not counted.
- R13: The response (`rsp_valid`, address, uncacheable, fault) is registered one clock after `req_valid`. `rsp_valid` is low on cycles that follow no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size_log | input | 2 | log2 of access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phys | input | 1 | Bypass translation |
| req_vpte | input | 1 | Page-table walk access |
| req_altmode | input | 1 | Use alternate mode under privileged code |
| req_nofault | input | 1 | Suppress fault latching |
| req_opcode | input | 6 | Opcode of the instruction, for status |
| req_ra | input | 5 | Register field, for status |
| pc_priv | input | 1 | Privileged-code indicator (PC bit 0) |
| cur_mode | input | 2 | Current processor mode |
| alt_mode | input | 2 | Alternate mode |
| cur_asn | input | 8 | Address-space number |
| pt_base | input | 64 | Page-table base for formatted address |
| lk_vpn | output | 30 | TLB lookup page number |
| lk_asn | output | 8 | TLB lookup address-space number |
| lk_hit | input | 1 | TLB hit |
| lk_ppn | input | 51 | TLB frame number |
| lk_rd_en | input | 4 | Per-mode read enables |
| lk_wr_en | input | 4 | Per-mode write enables |
| lk_fonr | input | 1 | Fault on read |
| lk_fonw | input | 1 | Fault on write |
| rsp_valid | output | 1 | Response valid |
| rsp_pa | output | 64 | Physical address |
| rsp_uc | output | 1 | Uncacheable |
| rsp_fault | output | 3 | Fault code |
| flt_va | output | 64 | Latched faulting address |
| flt_status | output | 17 | Latched status word |
| flt_form | output | 64 | Latched formatted address |
| cnt_rd_hit | output | 16 | Read hits |
| cnt_rd_miss | output | 16 | Read misses |
| cnt_rd_acv | output | 16 | Read violations |
| cnt_wr_hit | output | 16 | Write hits |
| cnt_wr_miss | output | 16 | Write misses |
| cnt_wr_acv | output | 16 | Write violations |

## Verification
Each priority boundary gets its own stimulus. A misaligned physical request tests whether a design lets the bypass skip the alignment check. A superpage access under privileged code with a user `cur_mode` catches a design that checks the effective mode there and wrongly grants access. Write permission failures must report a page fault, not a violation. The alternate-mode and privileged-override cases expose a wrong mode pick through the enable bit that gets consulted. Other cases include an uncacheable address next to one in the I/O window (wrong bit clearing shows up in the address), and walk and no-fault requests that must leave the latched status and address untouched. Counters are checked against totals derived from the expected codes, which catches alignment faults being counted or direction being swapped.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    typedef enum logic [1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ALIGN = 3'd1,
        FLT_ACV   = 3'd2,
        FLT_PAGE  = 3'd3,
        FLT_MISS  = 3'd4,
        FLT_DMISS = 3'd5,
        FLT_MCHK  = 3'd6
    } fault_e;

    typedef enum logic [1:0] {
        CLS_SKIP = 2'd0,
        CLS_HIT  = 2'd1,
        CLS_MISS = 2'd2,
        CLS_ACV  = 2'd3
    } cls_e;

    localparam int FL_W     = 6;
    localparam int FB_WR    = 0;
    localparam int FB_ACV   = 1;
    localparam int FB_BADVA = 2;
    localparam int FB_FONR  = 3;
    localparam int FB_FONW  = 4;
    localparam int FB_MISS  = 5;

    localparam int OPC_W = 6;
    localparam int RA_W  = 5;
    localparam int STAT_W = OPC_W + RA_W + FL_W;

    typedef struct packed {
        fault_e          code;
        logic [FL_W-1:0] flags;
    } verdict_t;

    function automatic cls_e fault_class(fault_e c);
        case (c)
            FLT_NONE, FLT_MCHK:  return CLS_HIT;
            FLT_MISS, FLT_DMISS: return CLS_MISS;
            FLT_ACV, FLT_PAGE:   return CLS_ACV;
            default:             return CLS_SKIP;
        endcase
    endfunction

    function automatic logic fault_latches(fault_e c);
        return (c != FLT_NONE) && (c != FLT_MCHK);
    endfunction

endpackage

// File: rtl/dxl_classify.sv
module dxl_classify
    import dxl_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int VA_IMPL    = 43,
    parameter int PA_IMPL    = 44,
    parameter int PG_SHIFT   = 13,
    parameter int SP_HI      = 47,
    parameter int SP_LO      = 41,
    parameter int SP_TAG     = 'h7E,
    parameter int SP_EXT_BIT = 40,
    parameter int IO_LSB     = 32,
    parameter int UC_CLR_LO  = 35,
    parameter int N_MODES    = 4,
    localparam int PPN_W     = VA_W - PG_SHIFT,
    localparam int MODE_W    = $clog2(N_MODES)
) (
    input  logic [VA_W-1:0]    va,
    input  logic [1:0]         size_log,
    input  logic               wr,
    input  logic               phys,
    input  logic               vpte,
    input  logic               priv,
    input  logic               use_alt,
    input  logic [MODE_W-1:0]  alt_mode,
    input  logic [MODE_W-1:0]  cur_mode,
    input  logic               lk_hit,
    input  logic [PPN_W-1:0]   lk_ppn,
    input  logic [N_MODES-1:0] lk_rd_en,
    input  logic [N_MODES-1:0] lk_wr_en,
    input  logic               lk_fonr,
    input  logic               lk_fonw,
    output verdict_t           verdict,
    output logic [VA_W-1:0]    pa,
    output logic               uc
);

    localparam int SP_W = SP_HI - SP_LO + 1;
    localparam logic [VA_W-1:0] IMPL_MASK = (VA_W'(1) << PA_IMPL) - VA_W'(1);
    localparam logic [VA_W-1:0] LOW_MASK  = (VA_W'(1) << SP_EXT_BIT) - VA_W'(1);
    localparam logic [VA_W-1:0] EXT_SET   = IMPL_MASK & ~LOW_MASK;

    logic [VA_W-1:0]   align_mask;
    logic              misalign;
    logic [MODE_W-1:0] eff_mode;
    logic              va_ok;
    logic              is_super;
    logic [VA_W-1:0]   sp_raw, sp_pa, tlb_pa, pa_raw;
    logic              in_io;

    always_comb begin
        align_mask = (VA_W'(1) << size_log) - VA_W'(1);
        misalign   = |(va & align_mask);
        eff_mode   = priv ? (use_alt ? alt_mode : MODE_W'(MODE_KERN)) : cur_mode;
        va_ok      = (&va[VA_W-1:VA_IMPL-1]) | ~(|va[VA_W-1:VA_IMPL-1]);
        is_super   = (va[SP_HI:SP_LO] == SP_W'(SP_TAG));
        sp_raw     = va & IMPL_MASK;
        sp_pa      = sp_raw[SP_EXT_BIT] ? (sp_raw | EXT_SET) : (sp_raw & LOW_MASK);
        tlb_pa     = {lk_ppn, va[PG_SHIFT-1:0]};
    end

    // Ordered checks: first failing stage decides the verdict
    always_comb begin
        verdict.code  = FLT_NONE;
        verdict.flags = '0;
        pa_raw        = va;
        if (misalign) begin
            verdict.code         = FLT_ALIGN;
            verdict.flags[FB_WR] = wr;
        end else if (!phys) begin
            if (!va_ok) begin
                verdict.code            = FLT_PAGE;
                verdict.flags[FB_WR]    = wr;
                verdict.flags[FB_BADVA] = 1'b1;
                verdict.flags[FB_ACV]   = 1'b1;
            end else if (is_super) begin
                if (cur_mode != MODE_W'(MODE_KERN)) begin
                    verdict.code          = FLT_ACV;
                    verdict.flags[FB_WR]  = wr;
                    verdict.flags[FB_ACV] = 1'b1;
                end else begin
                    pa_raw = sp_pa;
                end
            end else if (!lk_hit) begin
                verdict.code           = vpte ? FLT_DMISS : FLT_MISS;
                verdict.flags[FB_WR]   = wr;
                verdict.flags[FB_MISS] = 1'b1;
            end else begin
                pa_raw = tlb_pa;
                if (wr) begin
                    if (!lk_wr_en[eff_mode]) begin
                        verdict.code           = FLT_PAGE;
                        verdict.flags[FB_WR]   = 1'b1;
                        verdict.flags[FB_ACV]  = 1'b1;
                        verdict.flags[FB_FONW] = lk_fonw;
                    end else if (lk_fonw) begin
                        verdict.code           = FLT_PAGE;
                        verdict.flags[FB_WR]   = 1'b1;
                        verdict.flags[FB_FONW] = 1'b1;
                    end
                end else begin
                    if (!lk_rd_en[eff_mode]) begin
                        verdict.code           = FLT_ACV;
                        verdict.flags[FB_ACV]  = 1'b1;
                        verdict.flags[FB_FONR] = lk_fonr;
                    end else if (lk_fonr) begin
                        verdict.code           = FLT_PAGE;
                        verdict.flags[FB_FONR] = 1'b1;
                    end
                end
            end
        end

        pa    = pa_raw;
        uc    = 1'b0;
        in_io = &pa_raw[PA_IMPL-1:IO_LSB];
        if (verdict.code == FLT_NONE) begin
            if (|(pa_raw & ~IMPL_MASK)) begin
                verdict.code = FLT_MCHK;
            end else if (pa_raw[PA_IMPL-1] && !in_io) begin
                uc                        = 1'b1;
                pa[PA_IMPL-2:UC_CLR_LO]   = '0;
            end
        end
    end

endmodule

// File: rtl/dxl_fault_regs.sv
module dxl_fault_regs
    import dxl_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int VA_IMPL  = 43,
    parameter int PG_SHIFT = 13,
    parameter int FORM_SH  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  verdict_t          verdict,
    input  logic [VA_W-1:0]   va,
    input  logic              vpte,
    input  logic              nofault,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [RA_W-1:0]   ra,
    input  logic [VA_W-1:0]   pt_base,
    output logic [VA_W-1:0]   flt_va,
    output logic [STAT_W-1:0] flt_status,
    output logic [VA_W-1:0]   flt_form
);

    logic            capture;
    logic [VA_W-1:0] vpn_ext;

    always_comb begin
        capture = req_valid && fault_latches(verdict.code) && !vpte && !nofault;
        vpn_ext = VA_W'(va[VA_IMPL-1:PG_SHIFT]) << FORM_SH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_va     <= '0;
            flt_status <= '0;
            flt_form   <= '0;
        end else if (capture) begin
            flt_va     <= va;
            flt_status <= {opcode, ra, verdict.flags};
            flt_form   <= pt_base | vpn_ext;
        end
    end

    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_valid && (vpte || nofault) |=> $stable(flt_va) && $stable(flt_status) && $stable(flt_form)); // R11

endmodule

// File: rtl/dxl_counters.sv
module dxl_counters
    import dxl_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int N_CLS = 3,
    localparam int N_CNT = 2 * N_CLS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        wr,
    input  cls_e                        cls,
    output logic [N_CNT-1:0][CNT_W-1:0] cnt
);

    logic                     bump;
    logic [$clog2(N_CNT)-1:0] idx;

    always_comb begin
        bump = req_valid && (cls != CLS_SKIP);
        idx  = $clog2(N_CNT)'((wr ? N_CLS : 0) + int'(cls) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (bump) begin
            cnt[idx] <= cnt[idx] + CNT_W'(1);
        end
    end

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_valid && cls == CLS_SKIP |=> $stable(cnt)); // R12

endmodule

// File: rtl/dxl_check.sv
module dxl_check
    import dxl_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int VA_IMPL  = 43,
    parameter int PA_IMPL  = 44,
    parameter int PG_SHIFT = 13,
    parameter int ASN_W    = 8,
    parameter int CNT_W    = 16,
    parameter int N_MODES  = 4,
    localparam int PPN_W   = VA_W - PG_SHIFT,
    localparam int VPN_W   = VA_IMPL - PG_SHIFT,
    localparam int MODE_W  = $clog2(N_MODES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_va,
    input  logic [1:0]          req_size_log,
    input  logic                req_write,
    input  logic                req_phys,
    input  logic                req_vpte,
    input  logic                req_altmode,
    input  logic                req_nofault,
    input  logic [OPC_W-1:0]    req_opcode,
    input  logic [RA_W-1:0]     req_ra,
    input  logic                pc_priv,
    input  logic [MODE_W-1:0]   cur_mode,
    input  logic [MODE_W-1:0]   alt_mode,
    input  logic [ASN_W-1:0]    cur_asn,
    input  logic [VA_W-1:0]     pt_base,
    output logic [VPN_W-1:0]    lk_vpn,
    output logic [ASN_W-1:0]    lk_asn,
    input  logic                lk_hit,
    input  logic [PPN_W-1:0]    lk_ppn,
    input  logic [N_MODES-1:0]  lk_rd_en,
    input  logic [N_MODES-1:0]  lk_wr_en,
    input  logic                lk_fonr,
    input  logic                lk_fonw,
    output logic                rsp_valid,
    output logic [VA_W-1:0]     rsp_pa,
    output logic                rsp_uc,
    output logic [2:0]          rsp_fault,
    output logic [VA_W-1:0]     flt_va,
    output logic [STAT_W-1:0]   flt_status,
    output logic [VA_W-1:0]     flt_form,
    output logic [CNT_W-1:0]    cnt_rd_hit,
    output logic [CNT_W-1:0]    cnt_rd_miss,
    output logic [CNT_W-1:0]    cnt_rd_acv,
    output logic [CNT_W-1:0]    cnt_wr_hit,
    output logic [CNT_W-1:0]    cnt_wr_miss,
    output logic [CNT_W-1:0]    cnt_wr_acv
);

    verdict_t                verdict;
    logic [VA_W-1:0]         pa_c;
    logic                    uc_c;
    logic [5:0][CNT_W-1:0]   cnt;

    assign lk_vpn = req_va[VA_IMPL-1:PG_SHIFT];
    assign lk_asn = cur_asn;

    dxl_classify #(
        .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_IMPL(PA_IMPL),
        .PG_SHIFT(PG_SHIFT), .N_MODES(N_MODES)
    ) u_classify (
        .va(req_va), .size_log(req_size_log), .wr(req_write),
        .phys(req_phys), .vpte(req_vpte), .priv(pc_priv),
        .use_alt(req_altmode), .alt_mode(alt_mode), .cur_mode(cur_mode),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
        .lk_wr_en(lk_wr_en), .lk_fonr(lk_fonr), .lk_fonw(lk_fonw),
        .verdict(verdict), .pa(pa_c), .uc(uc_c)
    );

    dxl_fault_regs #(
        .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PG_SHIFT(PG_SHIFT)
    ) u_fault_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .verdict(verdict),
        .va(req_va), .vpte(req_vpte), .nofault(req_nofault),
        .opcode(req_opcode), .ra(req_ra), .pt_base(pt_base),
        .flt_va(flt_va), .flt_status(flt_status), .flt_form(flt_form)
    );

    dxl_counters #(.CNT_W(CNT_W)) u_counters (
        .clk(clk), .rst(rst), .req_valid(req_valid), .wr(req_write),
        .cls(fault_class(verdict.code)), .cnt(cnt)
    );

    assign cnt_rd_hit  = cnt[0];
    assign cnt_rd_miss = cnt[1];
    assign cnt_rd_acv  = cnt[2];
    assign cnt_wr_hit  = cnt[3];
    assign cnt_wr_miss = cnt[4];
    assign cnt_wr_acv  = cnt[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_uc    <= 1'b0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa    <= pa_c;
                rsp_uc    <= uc_c;
                rsp_fault <= verdict.code;
            end
        end
    end

    AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (rst)
        req_valid && |(req_va & ((VA_W'(1) << req_size_log) - VA_W'(1)))
        |=> rsp_fault == FLT_ALIGN); // R1
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R13
    AST_UC_CLEAN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_uc |-> rsp_fault == FLT_NONE && rsp_pa[PA_IMPL-2:35] == '0); // R10
    AST_PA_RANGE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault == FLT_NONE |-> rsp_pa[VA_W-1:PA_IMPL] == '0); // R9

endmodule

// File: tb/dxl_check_bench.sv
module dxl_check_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] va;
        logic [1:0]  szl;
        logic        wr, phys, vpte, pc0, alt;
        logic [1:0]  altm, curm;
        logic        hit;
        logic [50:0] ppn;
        logic [3:0]  rden, wren;
        logic        fonr, fonw;
        logic [2:0]  ef;
        logic [63:0] epa;
        logic        euc, elat;
        logic [5:0]  efl;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{64'h1004,3,1,1,0,0,0,0,0,0,51'h0,4'h0,4'h0,0,0, 3'd1,64'h0,0,1,6'h01},                     // R1 physical misaligned write
        '{64'h1002,2,0,0,0,0,0,0,0,1,51'h5,4'hF,4'hF,0,0, 3'd1,64'h0,0,1,6'h00},                     // R1 read misaligned
        '{64'h0000_0123_4567_89A8,3,0,1,0,0,0,0,0,0,51'h0,4'h0,4'h0,0,0, 3'd0,64'h0000_0123_4567_89A8,0,0,6'h0}, // R2
        '{64'h0010_0000_0000_0000,0,0,1,0,0,0,0,0,0,51'h0,4'h0,4'h0,0,0, 3'd6,64'h0,0,0,6'h0},       // R9 physical too wide
        '{64'h0000_0800_0000_6000,0,1,0,0,0,0,0,0,1,51'h1,4'hF,4'hF,0,0, 3'd3,64'h0,0,1,6'h07},      // R3
        '{64'hFFFF_FC00_0000_2000,3,0,0,0,0,0,0,0,0,51'h0,4'h0,4'h0,0,0, 3'd0,64'h2000,0,0,6'h0},   // R4 superpage low
        '{64'hFFFF_FD00_0000_4000,3,0,0,0,0,0,0,0,0,51'h0,4'h0,4'h0,0,0, 3'd0,64'h0000_0800_0000_4000,1,0,6'h0}, // R4 R10
        '{64'hFFFF_FC00_0000_2000,3,0,0,0,1,0,0,3,1,51'h1,4'hF,4'hF,0,0, 3'd2,64'h0,0,1,6'h02},      // R4 uses cur_mode
        '{64'hFFFF_FDFF_0000_0000,3,0,0,0,0,0,0,0,0,51'h0,4'h0,4'h0,0,0, 3'd0,64'h0000_0FFF_0000_0000,0,0,6'h0}, // R10 io window
        '{64'h4_6000,3,0,0,0,0,0,0,0,0,51'h0,4'h0,4'h0,0,0, 3'd4,64'h0,0,1,6'h20},                   // R6 single miss
        '{64'h4_6000,3,1,0,1,0,0,0,0,0,51'h0,4'h0,4'h0,0,0, 3'd5,64'h0,0,0,6'h0},                    // R6 double miss, no latch
        '{64'h4_6ABC,0,0,0,0,0,0,0,0,1,51'h123,4'h1,4'h0,0,0, 3'd0,64'h24_6ABC,0,0,6'h0},            // R9 hit address
        '{64'h4_6000,2,0,0,0,0,0,0,3,1,51'h1,4'h7,4'hF,1,0, 3'd2,64'h0,0,1,6'h0A},                   // R8 no read enable
        '{64'h4_6000,2,0,0,0,0,0,0,3,1,51'h1,4'h8,4'hF,1,0, 3'd3,64'h0,0,1,6'h08},                   // R8 fault on read
        '{64'h4_6000,2,1,0,0,0,0,0,3,1,51'h1,4'hF,4'h1,0,1, 3'd3,64'h0,0,1,6'h13},                   // R7 no write enable
        '{64'h4_6000,2,1,0,0,0,0,0,3,1,51'h1,4'hF,4'h8,0,1, 3'd3,64'h0,0,1,6'h11},                   // R7 fault on write
        '{64'h2010,3,1,0,0,1,0,0,3,1,51'h5,4'h0,4'h1,0,0, 3'd0,64'hA010,0,0,6'h0},                   // R5 privileged -> kernel
        '{64'h2010,3,0,0,0,1,1,2,0,1,51'h5,4'h4,4'h0,0,0, 3'd0,64'hA010,0,0,6'h0},                   // R5 alternate mode
        '{64'h2010,3,0,0,0,1,1,2,0,1,51'h5,4'h1,4'h0,0,0, 3'd2,64'h0,0,1,6'h02},                     // R5 alternate denies
        '{64'h6000,3,0,0,0,0,0,0,0,1,51'h8_0000_0000,4'hF,4'h0,0,0, 3'd6,64'h0,0,0,6'h0},            // R9 machine check
        '{64'h6008,3,0,0,0,0,0,0,0,1,51'h4200_0000,4'hF,4'h0,0,0, 3'd0,64'h0000_0800_0000_0008,1,0,6'h0} // R10 tlb uncacheable
    };

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, req_phys = 0, req_vpte = 0, req_altmode = 0, req_nofault = 0;
    logic [63:0] req_va = 0, pt_base = 0;
    logic [1:0]  req_size_log = 0, cur_mode = 0, alt_mode = 0;
    logic [5:0]  req_opcode = 6'h2A;
    logic [4:0]  req_ra = 5'h11;
    logic        pc_priv = 0;
    logic [7:0]  cur_asn = 8'h3C;
    logic        lk_hit = 0, lk_fonr = 0, lk_fonw = 0;
    logic [50:0] lk_ppn = 0;
    logic [3:0]  lk_rd_en = 0, lk_wr_en = 0;
    logic [29:0] lk_vpn;
    logic [7:0]  lk_asn;
    logic        rsp_valid, rsp_uc;
    logic [63:0] rsp_pa, flt_va, flt_form;
    logic [2:0]  rsp_fault;
    logic [16:0] flt_status;
    logic [15:0] cnt_rd_hit, cnt_rd_miss, cnt_rd_acv, cnt_wr_hit, cnt_wr_miss, cnt_wr_acv;

    int total = 0, bad = 0;
    bit finished = 0;
    int e_cnt [6];
    logic [16:0] e_stat;
    logic [63:0] e_fva;

    always #(CLK_PERIOD/2) clk = ~clk;

    dxl_check u_dxl_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_size_log(req_size_log), .req_write(req_write), .req_phys(req_phys),
        .req_vpte(req_vpte), .req_altmode(req_altmode), .req_nofault(req_nofault),
        .req_opcode(req_opcode), .req_ra(req_ra), .pc_priv(pc_priv),
        .cur_mode(cur_mode), .alt_mode(alt_mode), .cur_asn(cur_asn), .pt_base(pt_base),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en), .lk_fonr(lk_fonr), .lk_fonw(lk_fonw),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uc(rsp_uc), .rsp_fault(rsp_fault),
        .flt_va(flt_va), .flt_status(flt_status), .flt_form(flt_form),
        .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss), .cnt_rd_acv(cnt_rd_acv),
        .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss), .cnt_wr_acv(cnt_wr_acv)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void account(input logic wr, input logic [2:0] f);
        int base = wr ? 3 : 0;
        case (f)
            3'd0, 3'd6: e_cnt[base]++;
            3'd4, 3'd5: e_cnt[base+1]++;
            3'd2, 3'd3: e_cnt[base+2]++;
            default: ;
        endcase
    endfunction

    task automatic issue(input vec_t v, input logic nf);
        req_va = v.va; req_size_log = v.szl; req_write = v.wr; req_phys = v.phys;
        req_vpte = v.vpte; pc_priv = v.pc0; req_altmode = v.alt; alt_mode = v.altm;
        cur_mode = v.curm; lk_hit = v.hit; lk_ppn = v.ppn; lk_rd_en = v.rden;
        lk_wr_en = v.wren; lk_fonr = v.fonr; lk_fonw = v.fonw; req_nofault = nf;
        req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t d;
        foreach (e_cnt[k]) e_cnt[k] = 0;
        e_stat = '0;
        e_fva  = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // Reset state (R13, R11, R12)
        check("R13 reset rsp_valid", 64'(rsp_valid), 64'h0);
        check("R11 reset status", 64'(flt_status), 64'h0);
        check("R12 reset counter", 64'(cnt_rd_hit), 64'h0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i], 1'b0);
            check($sformatf("R13 row%0d valid", i), 64'(rsp_valid), 64'h1);
            check($sformatf("row%0d fault", i), 64'(rsp_fault), 64'(VEC[i].ef));
            if (VEC[i].ef == 3'd0) begin
                check($sformatf("row%0d pa", i), rsp_pa, VEC[i].epa);
                check($sformatf("R10 row%0d uc", i), 64'(rsp_uc), 64'(VEC[i].euc));
            end
            if (VEC[i].elat) begin
                e_stat = {6'h2A, 5'h11, VEC[i].efl};
                e_fva  = VEC[i].va;
            end
            check($sformatf("R11 row%0d status", i), 64'(flt_status), 64'(e_stat));
            check($sformatf("R11 row%0d fault va", i), flt_va, e_fva);
            account(VEC[i].wr, VEC[i].ef);
        end

        // R13: idle cycle reports no response
        @(negedge clk);
        check("R13 idle", 64'(rsp_valid), 64'h0);

        // R11 formatted address
        pt_base = 64'h1_0000_0000;
        d = VEC[4];
        issue(d, 1'b0);
        check("R11 form", flt_form, 64'h1_0000_0018);
        check("R3 fault", 64'(rsp_fault), 64'd3);
        account(1'b1, 3'd3);

        // R11 no-fault request: miss reported but nothing latched
        d = VEC[9];
        d.va = 64'h9_E000;
        pt_base = 64'h2_0000_0000;
        issue(d, 1'b1);
        check("R6 nofault miss code", 64'(rsp_fault), 64'd4);
        check("R11 nofault va kept", flt_va, 64'h0000_0800_0000_6000);
        check("R11 nofault form kept", flt_form, 64'h1_0000_0018);
        account(1'b0, 3'd4);

        // R12 counter totals
        check("R12 rd hit", 64'(cnt_rd_hit), 64'(e_cnt[0]));
        check("R12 rd miss", 64'(cnt_rd_miss), 64'(e_cnt[1]));
        check("R12 rd acv", 64'(cnt_rd_acv), 64'(e_cnt[2]));
        check("R12 wr hit", 64'(cnt_wr_hit), 64'(e_cnt[3]));
        check("R12 wr miss", 64'(cnt_wr_miss), 64'(e_cnt[4]));
        check("R12 wr acv", 64'(cnt_wr_acv), 64'(e_cnt[5]));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule